// File: doc/BRIEF.md
# Trigger Frame Serializer

This block turns trigger requests and timing-counter reset requests into a fixed-length serial frame on a single line, one bit per clock cycle. Each frame holds a start marker, an action code, the trigger type flags, and the number of the event. Downstream receivers sample that line against the same clock. Frames may start only at the beginning of fixed-length slots of `SLOT_CYCLES` clocks, so the frame rate is set by the slot length and not by how often requests arrive.

A request that arrives between slot starts, or while a frame is on the line, is held. It goes out at the next slot start. A trigger request and a reset request that are pending at the same time leave as one combined frame. The block keeps its own event counter. The number a frame carries is the count before that frame. The count advances only for frames that carry a trigger. Bits are launched on the falling clock edge so that the receivers sample them mid-bit on the rising edge.

Top module: `trig_frame_ser`

## Requirements
- R1: A frame is `FRAME_BITS` = 1 + 2 + `TYPE_W` + `EVT_W` bits long (38 by default), one bit per clock, most significant bit first. `busy_o` rises half a cycle before the first bit and is high for exactly `FRAME_BITS` clock cycles.
- R2: The first bit of every frame is 1. Whenever no frame is being sent, `serial_o` is 0.
- R3: Bits 2 and 3 of the frame are the action code, sent MSB first: 10 means trigger only, 01 means counter reset only, 11 means both.
- R4: The next `TYPE_W` bits are the type word, sent MSB first. The word is captured from `trig_type_i` in the cycle the trigger request is seen. Later changes of `trig_type_i` do not alter it. It is all zeros in a reset-only frame.
- R5: The last `EVT_W` bits are the event number, sent MSB first. The first frame after reset carries 0. The number increases by one after each frame whose code has the trigger bit set, and is unchanged by a reset-only frame.
- R6: The event number wraps from 2^`EVT_W`-1 to 0.
- R7: A frame is loaded only on the rising edge at the start of a slot. The first such edge is the first rising edge after reset release, and the next ones follow every `SLOT_CYCLES` edges. The header bit appears at the following falling edge. Counting rising edges since release from 1, the header is therefore sampled after edge n with n mod `SLOT_CYCLES` = 2.
- R8: A request that arrives while a frame is in progress, or before the next slot start, is held and sent in the next slot. If no request is pending, no frame is sent and `busy_o` stays 0.
- R9: A trigger request and a counter-reset request pending in the same slot produce a single frame with code 11.
- R10: While `rst_ni` is low, `serial_o` and `busy_o` are 0 at once, even in the middle of a frame, and the event number returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock; bits launch on its falling edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_req_i | input | 1 | Trigger request, sampled on the rising edge |
| tdc_req_i | input | 1 | Timing-counter reset request, sampled on the rising edge |
| trig_type_i | input | TYPE_W | Trigger type flags, captured with the trigger request |
| serial_o | output | 1 | Serial frame line, idle low |
| busy_o | output | 1 | High while a frame is being shifted out |

## Verification
A request is latched on the rising edge where it is seen. It is loaded on the next slot-start edge, where `busy_o` rises. The header reaches `serial_o` at the falling edge half a cycle later, and each later bit follows one cycle after the one before. The bench drives and samples 2 ns after each rising edge, in the middle of the high phase of the bit that was launched at the falling edge before. It waits for the header and then reads exactly `FRAME_BITS` samples. It checks the header cycle against the slot grid, with the count taken from its own edge counter. `busy_o` is high in every sample from the header up to, but not including, the last bit, which gives `FRAME_BITS`-1 high samples. The sample after the last bit must show an idle line.

// File: rtl/trig_frame_pkg.sv
package trig_frame_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_TDC  = 2'b01,
    ACT_TRIG = 2'b10,
    ACT_BOTH = 2'b11
  } act_e;

  localparam int unsigned HDR_W = 1;
  localparam int unsigned ACT_W = 2;
endpackage

// File: rtl/trig_req_latch.sv
module trig_req_latch
  import trig_frame_pkg::*;
#(
  parameter int unsigned TYPE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_req_i,
  input  logic              tdc_req_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic              take_i,
  output act_e              act_o,
  output logic [TYPE_W-1:0] type_o
);
  logic              pend_trig_q, pend_tdc_q;
  logic [TYPE_W-1:0] type_q;

  // requests seen on the launch edge belong to the next slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_trig_q <= 1'b0;
      pend_tdc_q  <= 1'b0;
      type_q      <= '0;
    end else begin
      pend_trig_q <= (pend_trig_q && !take_i) || trig_req_i;
      pend_tdc_q  <= (pend_tdc_q && !take_i) || tdc_req_i;
      if (trig_req_i)  type_q <= type_i;
      else if (take_i) type_q <= '0;
    end
  end

  assign act_o  = act_e'({pend_trig_q, pend_tdc_q});
  assign type_o = pend_trig_q ? type_q : '0;

  p_hold_trig_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_trig_q && !take_i) |=> pend_trig_q);
  p_hold_tdc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_tdc_q && !take_i) |=> pend_tdc_q);
  p_type_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_trig_q && !take_i && !trig_req_i) |=> $stable(type_o));
endmodule

// File: rtl/trig_slot_timer.sv
module trig_slot_timer #(
  parameter int unsigned SLOT_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic slot_start_o
);
  localparam int unsigned CNT_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign slot_start_o = (cnt_q == '0);

  p_slot_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LAST) |=> slot_start_o);
  p_slot_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/trig_frame_shifter.sv
module trig_frame_shifter #(
  parameter int unsigned FRAME_BITS = 38
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  output logic                  busy_o,
  output logic                  serial_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_BITS + 1);

  logic [FRAME_BITS-1:0] sh_q;
  logic [CNT_W-1:0]      left_q;
  logic                  busy_q;
  logic                  line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load_i) begin
      sh_q   <= frame_i;
      left_q <= CNT_W'(FRAME_BITS);
    end else if (left_q != '0) begin
      sh_q   <= {sh_q[FRAME_BITS-2:0], 1'b0};
      left_q <= left_q - 1'b1;
    end
  end

  assign busy_q = (left_q != '0);

  // launch on the falling edge so receivers sample mid-bit
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= 1'b0;
    else         line_q <= busy_q & sh_q[FRAME_BITS-1];
  end

  assign busy_o   = busy_q;
  assign serial_o = line_q;

  p_no_overlap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_q);
  p_header_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> serial_o);
  p_idle_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !$past(busy_q)) |-> !serial_o);
  p_busy_len_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> busy_q);
endmodule

// File: rtl/trig_frame_ser.sv
module trig_frame_ser
  import trig_frame_pkg::*;
#(
  parameter int unsigned EVT_W       = 32,
  parameter int unsigned TYPE_W      = 3,
  parameter int unsigned SLOT_CYCLES = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_req_i,
  input  logic              tdc_req_i,
  input  logic [TYPE_W-1:0] trig_type_i,
  output logic              serial_o,
  output logic              busy_o
);
  localparam int unsigned FRAME_BITS = HDR_W + ACT_W + TYPE_W + EVT_W;

  initial begin
    a_slot_fits_r8: assert (SLOT_CYCLES > FRAME_BITS);
  end

  act_e              act;
  logic [TYPE_W-1:0] type_w;
  logic              slot_start;
  logic              launch;
  logic              busy;
  logic [EVT_W-1:0]  evt_q;
  logic [FRAME_BITS-1:0] frame;

  trig_req_latch #(.TYPE_W(TYPE_W)) u_req (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_req_i (trig_req_i),
    .tdc_req_i  (tdc_req_i),
    .type_i     (trig_type_i),
    .take_i     (launch),
    .act_o      (act),
    .type_o     (type_w)
  );

  trig_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_slot (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .slot_start_o (slot_start)
  );

  assign launch = slot_start && (act != ACT_NONE) && !busy;
  assign frame  = {1'b1, act, type_w, evt_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   evt_q <= '0;
    else if (launch && act[1])     evt_q <= evt_q + 1'b1;
  end

  trig_frame_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (launch),
    .frame_i  (frame),
    .busy_o   (busy),
    .serial_o (serial_o)
  );

  assign busy_o = busy;

  p_evt_inc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch && act[1]) |=> (evt_q == $past(evt_q) + 1'b1));
  p_evt_tdc_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch && act == ACT_TDC) |=> $stable(evt_q));
  p_evt_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !launch |=> $stable(evt_q));
  p_load_on_slot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(slot_start));
endmodule

// File: tb/trig_frame_ser_tb.sv
module trig_frame_ser_tb;
  localparam int SLOT   = 1000;
  localparam int NB     = 38;
  localparam int SLOT_S = 20;
  localparam int NB_S   = 9;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic       trig_req = 0, tdc_req = 0;
  logic [2:0] ttype = '0;
  logic       ser, busy;
  logic       trig_s = 0, tdc_s = 0;
  logic [2:0] type_s = '0;
  logic       ser_s, busy_s;

  int total = 0, bad = 0, cyc = 0;
  logic [31:0] evt_m = '0;

  trig_frame_ser u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .trig_req_i(trig_req), .tdc_req_i(tdc_req),
    .trig_type_i(ttype), .serial_o(ser), .busy_o(busy));

  trig_frame_ser #(.EVT_W(3), .TYPE_W(3), .SLOT_CYCLES(SLOT_S)) u_dut_w (
    .clk_i(clk), .rst_ni(rst_ni), .trig_req_i(trig_s), .tdc_req_i(tdc_s),
    .trig_type_i(type_s), .serial_o(ser_s), .busy_o(busy_s));

  always @(posedge clk) cyc <= rst_ni ? cyc + 1 : 0;

  // {trig, tdc, type, exp_code, exp_type}
  localparam logic [9:0] VEC [6] = '{
    {1'b1, 1'b0, 3'b101, 2'b10, 3'b101},
    {1'b0, 1'b1, 3'b111, 2'b01, 3'b000},
    {1'b1, 1'b1, 3'b010, 2'b11, 3'b010},
    {1'b1, 1'b0, 3'b000, 2'b10, 3'b000},
    {1'b0, 1'b1, 3'b011, 2'b01, 3'b000},
    {1'b1, 1'b0, 3'b111, 2'b10, 3'b111}
  };

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic capture(input bit sm, input int nb, input int slot,
                         output logic [63:0] f, output int hc);
    int w = 0;
    int bc = 0;
    f = '0;
    while (((sm ? ser_s : ser) !== 1'b1) && w < 3 * slot) begin
      tick();
      w++;
    end
    hc = cyc;
    for (int i = 0; i < nb; i++) begin
      f = {f[62:0], (sm ? ser_s : ser)};
      if ((sm ? busy_s : busy) === 1'b1) bc++;
      tick();
    end
    chk("R2 idle after frame", longint'(sm ? ser_s : ser), 0);
    chk("R1 busy cycles", bc, nb - 1);
    chk("R7 slot alignment", hc % slot, 2);
  endtask

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] f;
    int ha, hb, n0;
    #3;
    chk("R10 reset serial", ser, 0);
    chk("R10 reset busy", busy, 0);
    #20;
    rst_ni = 1'b1;
    tick();

    // table of vectors
    for (int i = 0; i < 6; i++) begin
      logic [9:0] v;
      v = VEC[i];
      trig_req = v[9]; tdc_req = v[8]; ttype = v[7:5];
      tick();
      trig_req = 0; tdc_req = 0; ttype = ~v[7:5];
      capture(0, NB, SLOT, f, ha);
      chk("R2 header", f[37], 1);
      chk("R3 code", f[36:35], v[4:3]);
      chk("R4 type", f[34:32], v[2:0]);
      chk("R5 event", f[31:0], evt_m);
      if (v[9]) evt_m++;
    end

    // merge of separate requests in one slot
    trig_req = 1; ttype = 3'b110;
    tick();
    trig_req = 0; ttype = 3'b001;
    tick(); tick();
    tdc_req = 1;
    tick();
    tdc_req = 0;
    capture(0, NB, SLOT, f, ha);
    chk("R9 merged code", f[36:35], 2'b11);
    chk("R4 merged type", f[34:32], 3'b110);
    chk("R5 merged event", f[31:0], evt_m);
    evt_m++;

    // request during a frame goes to the next slot
    trig_req = 1; ttype = 3'b100;
    tick();
    trig_req = 0;
    n0 = 0;
    while (busy !== 1'b1 && n0 < 3 * SLOT) begin tick(); n0++; end
    trig_req = 1; ttype = 3'b011;
    tick();
    trig_req = 0; ttype = 3'b000;
    capture(0, NB, SLOT, f, ha);
    chk("R8 first frame type", f[34:32], 3'b100);
    chk("R5 first frame event", f[31:0], evt_m);
    evt_m++;
    capture(0, NB, SLOT, f, hb);
    chk("R8 next slot", hb - ha, SLOT);
    chk("R8 held type", f[34:32], 3'b011);
    chk("R5 held event", f[31:0], evt_m);
    evt_m++;

    // no request: line stays idle
    n0 = 0;
    for (int i = 0; i < SLOT + 100; i++) begin
      if (ser !== 1'b0 || busy !== 1'b0) n0++;
      tick();
    end
    chk("R8 idle without request", n0, 0);

    // wrap on the narrow instance
    for (int k = 0; k < 9; k++) begin
      trig_s = 1; type_s = 3'(k);
      tick();
      trig_s = 0;
      capture(1, NB_S, SLOT_S, f, ha);
      chk("R6 wrap event", f[2:0], k % 8);
      chk("R3 narrow code", f[7:6], 2'b10);
    end

    // reset in the middle of a frame
    trig_req = 1; ttype = 3'b101;
    tick();
    trig_req = 0;
    n0 = 0;
    while (busy !== 1'b1 && n0 < 3 * SLOT) begin tick(); n0++; end
    tick(); tick();
    rst_ni = 1'b0;
    #1;
    chk("R10 async serial", ser, 0);
    chk("R10 async busy", busy, 0);
    tick();
    rst_ni = 1'b1;
    evt_m = '0;
    tick();
    trig_req = 1; ttype = 3'b010;
    tick();
    trig_req = 0;
    capture(0, NB, SLOT, f, ha);
    chk("R10 event cleared", f[31:0], 0);
    chk("R4 type after reset", f[34:32], 3'b010);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule